// File: doc/BRIEF.md
# SAR ADC conversion controller

This block is the digital sequencer of an 8-bit successive-approximation converter. It watches a convert request. Once the request is accepted, it spends a short internal reset. It then runs fixed-length conversion frames. Each frame starts by latching the channel select for the external analog multiplexer. A settling window follows. The block then makes one trial per bit, starting with the most significant bit. In each trial it drives a code to the external DAC and reads a one-bit comparator decision.

After the last trial, the resolved code goes into an output register and an end-of-conversion strobe is raised. Frames repeat back to back while the request stays high. A sleep input abandons any work and holds the block idle. The DAC, the comparator, the multiplexer and the references sit outside this block.

The result leaves the block as a register plus a one-cycle strobe, with no back-pressure. A consumer that misses the strobe can still read the register until the next strobe. The request, sleep, busy and strobe pins are plain levels.

Top module: `sar_conv_ctrl`

## Requirements
- R1: `conv_req` is accepted only when it is high on two consecutive rising edges of `clk` while `sleep` is low and no conversion is active. A request that is high on one edge only is ignored, and `busy` stays low.
- R2: The edge that accepts the request is followed by two internal reset cycles. `busy` rises after the third rising edge counted from the acceptance edge. Counting the acceptance edge as the second edge with `conv_req` high, `busy` is high from the 4th edge. The first `eoc` is high after the 18th edge.
- R3: If `conv_req` is high on the last edge of a frame, a new frame starts and the next `eoc` comes exactly 14 cycles after the previous one. If `conv_req` is low on that edge, `busy` falls and no further `eoc` occurs.
- R4: `cmp_hi` = 1 means the analog input is at or above `dac_code`. A trial bit stays set when `cmp_hi` is 1 and is cleared otherwise, from bit 7 down to bit 0. With an ideal comparator, `dout` equals the input code of the selected channel, including 0x00 and 0xFF.
- R5: `mux_sel` takes the value of `chan_sel` on the edge that starts a frame. Code n selects channel n. Changes of `chan_sel` during a frame do not change `mux_sel`.
- R6: `eoc` is high for exactly one cycle, in the cycle in which `dout` takes its new value. `dout` holds its value at all other times.
- R7: While `sleep` is high, any conversion is abandoned and `busy` is low from the next cycle. No `eoc` occurs, `dout` keeps its last value, and requests are not accepted.
- R8: After reset, `busy`, `eoc`, `dout` and `mux_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_req | input | 1 | Convert request, active high |
| sleep | input | 1 | Power-saving request, active high |
| chan_sel | input | 3 | Requested analog channel |
| cmp_hi | input | 1 | Comparator decision: input at or above `dac_code` |
| dac_code | output | 8 | Trial code for the external DAC |
| mux_sel | output | 3 | Channel latched for the current frame |
| busy | output | 1 | A conversion frame is running |
| eoc | output | 1 | One-cycle end-of-conversion strobe |
| dout | output | 8 | Last conversion result |

## Verification
Bursts of one to four frames run against a behavioural comparator. Each burst uses random per-channel input codes plus the corner codes 0x00, 0xFF, 0x80 and 0x7F. A wrong keep-or-clear rule or a wrong bit order shows up as a mismatched code at these corners.

During every frame, `chan_sel` is scrambled and then set to the next wanted channel just before the frame boundary. This separates latching at the frame start from following the input. The strobe cycle count tells the 18-cycle first frame apart from the 14-cycle repeat frames and from a run-on after the request drops. Single-edge pulses and a sleep asserted mid-frame check the cases that must not change the outputs.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESET = 2'd1,
    ST_FRAME = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sarc_req_filter.sv
module sarc_req_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_req,
  output logic req_ok
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= conv_req;
  end

  // high on this edge and on the one before
  assign req_ok = conv_req & req_q;
endmodule

// File: rtl/sarc_frame_seq.sv
module sarc_frame_seq
  import sarc_pkg::*;
#(
  parameter int NBITS   = 8,
  parameter int SETTLE  = 6,
  parameter int RST_CYC = 2,
  localparam int FRAME  = SETTLE + NBITS,
  localparam int FCW    = $clog2(FRAME),
  localparam int RCW    = $clog2(RST_CYC + 1),
  localparam int BW     = $clog2(NBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_ok,
  input  logic          conv_req,
  input  logic          sleep,
  output logic          busy,
  output logic          frame_start,
  output logic          settle_end,
  output logic          trial_en,
  output logic [BW-1:0] trial_idx,
  output logic          frame_last
);
  localparam logic [FCW-1:0] F_LAST   = FCW'(FRAME - 1);
  localparam logic [FCW-1:0] F_SETTLE = FCW'(SETTLE);
  localparam logic [FCW-1:0] F_SEND   = FCW'(SETTLE - 1);
  localparam logic [RCW-1:0] R_LAST   = RCW'(RST_CYC - 1);

  seq_state_e     state;
  logic [FCW-1:0] fcnt;
  logic [RCW-1:0] rcnt;
  logic [FCW-1:0] step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      fcnt  <= '0;
      rcnt  <= '0;
    end else if (sleep) begin
      state <= ST_IDLE;
      fcnt  <= '0;
      rcnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_ok) begin
          state <= ST_RESET;
          rcnt  <= '0;
        end
        ST_RESET: if (rcnt == R_LAST) begin
          state <= ST_FRAME;
          fcnt  <= '0;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
        ST_FRAME: if (fcnt == F_LAST) begin
          fcnt <= '0;
          if (!conv_req) state <= ST_IDLE;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy        = (state == ST_FRAME);
    frame_last  = busy && (fcnt == F_LAST);
    settle_end  = busy && (fcnt == F_SEND);
    trial_en    = busy && (fcnt >= F_SETTLE);
    step        = fcnt - F_SETTLE;
    trial_idx   = BW'(NBITS - 1) - step[BW-1:0];
    frame_start = !sleep &&
                  (((state == ST_RESET) && (rcnt == R_LAST)) ||
                   (frame_last && conv_req));
  end
endmodule

// File: rtl/sarc_sar_core.sv
module sarc_sar_core #(
  parameter int NBITS = 8,
  localparam int BW   = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             settle_end,
  input  logic             trial_en,
  input  logic [BW-1:0]    trial_idx,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] dac_code,
  output logic [NBITS-1:0] sar_next
);
  logic [NBITS-1:0] sar;

  always_comb begin
    sar_next = sar;
    for (int i = 0; i < NBITS; i++) begin
      if (BW'(i) == trial_idx)
        sar_next[i] = cmp_hi;
      else if ((trial_idx != '0) && (BW'(i) == trial_idx - 1'b1))
        sar_next[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          sar <= '0;
    else if (settle_end) sar <= {1'b1, {(NBITS-1){1'b0}}};
    else if (trial_en)   sar <= sar_next;
  end

  assign dac_code = sar;
endmodule

// File: rtl/sarc_out_reg.sv
module sarc_out_reg #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] d,
  output logic [NBITS-1:0] dout,
  output logic             eoc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
      eoc  <= 1'b0;
    end else begin
      eoc <= load;
      if (load) dout <= d;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int NBITS   = 8,
  parameter int CH_W    = 3,
  parameter int SETTLE  = 6,
  parameter int RST_CYC = 2,
  localparam int BW     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_req,
  input  logic             sleep,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] dac_code,
  output logic [CH_W-1:0]  mux_sel,
  output logic             busy,
  output logic             eoc,
  output logic [NBITS-1:0] dout
);
  logic             req_ok;
  logic             frame_start;
  logic             settle_end;
  logic             trial_en;
  logic [BW-1:0]    trial_idx;
  logic             frame_last;
  logic [NBITS-1:0] sar_next;

  sarc_req_filter u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_req (conv_req),
    .req_ok   (req_ok)
  );

  sarc_frame_seq #(.NBITS(NBITS), .SETTLE(SETTLE), .RST_CYC(RST_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ok      (req_ok),
    .conv_req    (conv_req),
    .sleep       (sleep),
    .busy        (busy),
    .frame_start (frame_start),
    .settle_end  (settle_end),
    .trial_en    (trial_en),
    .trial_idx   (trial_idx),
    .frame_last  (frame_last)
  );

  sarc_sar_core #(.NBITS(NBITS)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .settle_end (settle_end && !sleep),
    .trial_en   (trial_en && !sleep),
    .trial_idx  (trial_idx),
    .cmp_hi     (cmp_hi),
    .dac_code   (dac_code),
    .sar_next   (sar_next)
  );

  sarc_out_reg #(.NBITS(NBITS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_last && !sleep),
    .d     (sar_next),
    .dout  (dout),
    .eoc   (eoc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           mux_sel <= '0;
    else if (frame_start) mux_sel <= chan_sel;
  end
endmodule

// File: rtl/sarc_checks.sv
module sarc_checks #(
  parameter int NBITS = 8,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep,
  input logic [CH_W-1:0]  mux_sel,
  input logic             busy,
  input logic             eoc,
  input logic [NBITS-1:0] dout
);
  // R6: strobe lasts one cycle
  a_r6_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> !eoc);

  // R6: result register only moves with the strobe
  a_r6_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> $stable(dout));

  // R7: sleep drops busy and blocks the strobe
  a_r7_sleep_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!busy && !eoc));

  // R5: channel fixed inside a running frame
  a_r5_chan_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !eoc) |-> $stable(mux_sel));

  // R3: a strobe only closes a running frame
  a_r3_eoc_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> $past(busy));
endmodule

bind sar_conv_ctrl sarc_checks #(.NBITS(NBITS), .CH_W(CH_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sleep   (sleep),
  .mux_sel (mux_sel),
  .busy    (busy),
  .eoc     (eoc),
  .dout    (dout)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_req = 1'b0;
  logic       sleep = 1'b0;
  logic [2:0] chan_sel = 3'd0;
  logic       cmp_hi;
  logic [7:0] dac_code;
  logic [2:0] mux_sel;
  logic       busy;
  logic       eoc;
  logic [7:0] dout;
  logic [7:0] vin [8];

  int nvec = 0;
  int nbad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sar_conv_ctrl uut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .sleep(sleep),
    .chan_sel(chan_sel), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .mux_sel(mux_sel), .busy(busy), .eoc(eoc), .dout(dout)
  );

  // ideal comparator on the latched channel
  assign cmp_hi = (vin[mux_sel] >= dac_code);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_code(input int k);
    case (k % 6)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'h80;
      3: return 8'h7F;
      default: return 8'($urandom);
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic run_burst(input int n);
    int chs[4];
    int stray;
    for (int k = 0; k < 4; k++) chs[k] = int'($urandom % 8);
    chan_sel = 3'(chs[0]);
    conv_req = 1'b1;
    stray = 0;
    for (int k = 0; k < n; k++) begin
      int len = (k == 0) ? 18 : 14;
      int g   = (k == 0) ? 4 : 1;
      for (int i = 1; i <= len; i++) begin
        @(negedge clk);
        if (k == 0 && i == 3) check(busy == 1'b0, "R2 busy before reset done", busy, 0);
        if (k == 0 && i == 4) check(busy == 1'b1, "R2 busy after reset", busy, 1);
        if (k > 0 && i == 1) check(eoc == 1'b0, "R6 eoc single cycle", eoc, 0);
        if (i < len && eoc) stray++;
        if (i == 10) check(mux_sel == 3'(chs[k]), "R5 channel latched", mux_sel, chs[k]);
        if (i == len - 1 && k > 0)
          check(dout == vin[chs[k-1]], "R6 dout held", dout, vin[chs[k-1]]);
        if (i == len) begin
          check(eoc == 1'b1, (k == 0) ? "R2 first eoc at 18" : "R3 repeat eoc at 14", eoc, 1);
          check(dout == vin[chs[k]], "R4 result code", dout, vin[chs[k]]);
        end
        if (k == n - 1 && i == g) conv_req = 1'b0;
        if (i >= g && i < len - 1) chan_sel = 3'($urandom);
        if (i == len - 1 && k < n - 1) chan_sel = 3'(chs[k+1]);
      end
    end
    check(stray == 0, "R3 no early eoc", stray, 0);
    stray = 0;
    @(negedge clk);
    check(busy == 1'b0, "R3 busy drops after request", busy, 0);
    check(eoc == 1'b0, "R6 eoc single cycle", eoc, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (eoc || busy) stray++;
    end
    check(stray == 0, "R3 no run-on after request drop", stray, 0);
  endtask

  initial begin
    logic [7:0] held;
    int hits;
    void'($urandom(32'h5A12C3));
    for (int c = 0; c < 8; c++) vin[c] = pick_code(c);
    repeat (3) @(negedge clk);
    check(busy == 0 && eoc == 0, "R8 reset flags", {busy, eoc}, 0);
    check(dout == 8'h00, "R8 reset dout", dout, 0);
    check(mux_sel == 3'd0, "R8 reset mux_sel", mux_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: single-edge pulse ignored
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    hits = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (busy || eoc) hits++;
    end
    check(hits == 0, "R1 short pulse ignored", hits, 0);
    check(dout == 8'h00, "R1 dout untouched", dout, 0);

    // R1/R2/R3/R4/R5 bursts with corner and random codes
    for (int b = 0; b < 12; b++) begin
      for (int c = 0; c < 8; c++) vin[c] = pick_code(c + b);
      run_burst(1 + (b % 4));
    end

    // R7: sleep mid-frame
    held = dout;
    for (int c = 0; c < 8; c++) vin[c] = ~held;
    conv_req = 1'b1;
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R7 busy before sleep", busy, 1);
    sleep = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R7 busy drops on sleep", busy, 0);
    hits = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || eoc) hits++;
    end
    check(hits == 0, "R7 no conversion in sleep", hits, 0);
    check(dout == held, "R7 dout kept", dout, held);
    conv_req = 1'b0;
    sleep = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R7 idle after sleep", busy, 0);

    for (int c = 0; c < 8; c++) vin[c] = 8'($urandom);
    run_burst(3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule